// File: doc/BRIEF.md
# ISDN 2B+D Frame Channel Packer

This block is the bit-level serial port for a basic-rate 2B+D time-division line. A bit clock (`dcl`) and a frame-sync pulse (`fsync`) arrive as ordinary inputs and are sampled by the system clock `clk`. Every frame holds eighteen bit slots: eight for the first bearer channel, eight for the second, then two signalling bits. On the receive side the block takes the bits of both bearer channels and the signalling channel off the line. Each bearer channel is collected into its own 32-bit word over four frames, and a full flag is raised when a word is complete. On the transmit side the block does the reverse. It takes a 32-bit word for each bearer channel and an 8-bit signalling byte at the start of each four-frame group, and sends them out in the matching slots.

Each bearer channel has its own bit-order mode. In HDLC-encoded mode the least significant bit is on the line first. In unencoded mode the most significant bit is first. The placement of bytes inside the word does not depend on the mode: the byte from the first frame of a group always sits in bits 31:24 and the byte from the fourth frame in bits 7:0. The signalling bits are packed in arrival order, starting at bit 0.

A slot sequencer drives the block. Its states are `SL_IDLE`, `SL_B1`, `SL_B2` and `SL_D`, and it changes state only on a rising edge of `dcl`:
- A rising edge with `fsync` high always moves it to `SL_B1` at bit 0. This is the "sync" transition.
- It moves from `SL_B1` to `SL_B2` after bit 7, and from `SL_B2` to `SL_D` after bit 7.
- It moves from `SL_D` to `SL_IDLE` after bit 1. This is the "frame end" transition, and it advances the frame index modulo 4.
- `SL_IDLE` holds until the next sync.

Line data is sampled on falling edges of `dcl`. Line data is driven from the state that was entered on the rising edge.

Top module: `isdn_frame_packer`

## Requirements
- R1: After a rising `dcl` edge with `fsync` high, the next 18 bit slots are B1 bits 0..7, B2 bits 0..7 and D bits 0..1. `dout_en` is 1 only inside these slots. Outside them `dout_en` is 0 and `dout` is 1.
- R2: A B channel whose mode input is 1 (HDLC-encoded) is received least significant bit first. The bit sampled in slot k of the channel becomes bit k of its byte.
- R3: A B channel whose mode input is 0 (unencoded) is received most significant bit first. The bit sampled in slot k becomes bit 7-k of its byte.
- R4: The receive word of a channel is updated only when the fourth byte of a group completes. It then holds the byte of frame 0 in bits 31:24, frame 1 in 23:16, frame 2 in 15:8 and frame 3 in 7:0.
- R5: The full flag of a channel rises on the clock after its word completes. A one-clock read strobe clears it. The full and overrun flags are 0 after reset.
- R6: If a word completes while the channel is full and no read strobe is present, the overrun flag is set. A read strobe clears it. If a read strobe and a completion fall in the same clock, the new word is stored, full stays 1 and overrun ends at 0.
- R7: At each group start (a sync with the next frame index 0), a pending transmit word is copied into the channel's shadow. It is then sent with the channel's bit order (R2/R3) and byte placement (R4).
- R8: If no word is pending at a group start, the channel sends 1 in all of its slots for the whole group, and its underrun output is 1 until the next group start that finds a word.
- R9: In receive frame f, signalling bit j is stored at bit 2f+j of the D byte. After the second D bit of frame 3, `rx_d_byte` is updated and `rx_d_stb` pulses for one clock.
- R10: `tx_d_byte` is captured at each group start. Its bit 2f+j is sent in D slot j of frame f.
- R11: A sync that arrives before the last D slot of a frame restarts B1 at bit 0 and does not advance the frame index. A sync on the rising edge that ends the last D slot (back-to-back frames) does advance it.
- R12: A load strobe in the same clock as a group start sends that word in the starting group, with no underrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dcl | input | 1 | Line bit clock, synchronous to `clk` |
| fsync | input | 1 | Frame-sync, sampled at rising `dcl` edges |
| din | input | 1 | Receive line data |
| mode_b1_hdlc | input | 1 | B1 bit order: 1 = LSB first, 0 = MSB first |
| mode_b2_hdlc | input | 1 | B2 bit order: 1 = LSB first, 0 = MSB first |
| rd_b1 | input | 1 | Read strobe for the B1 receive word |
| rd_b2 | input | 1 | Read strobe for the B2 receive word |
| rx_b1_word | output | 32 | Last completed B1 receive word |
| rx_b2_word | output | 32 | Last completed B2 receive word |
| rx_b1_full | output | 1 | B1 word waiting to be read |
| rx_b2_full | output | 1 | B2 word waiting to be read |
| rx_b1_ovr | output | 1 | B1 overrun |
| rx_b2_ovr | output | 1 | B2 overrun |
| rx_d_byte | output | 8 | Signalling bits of the last group |
| rx_d_stb | output | 1 | One-clock pulse when `rx_d_byte` updates |
| tx_b1_load | input | 1 | Load strobe for `tx_b1_word` |
| tx_b2_load | input | 1 | Load strobe for `tx_b2_word` |
| tx_b1_word | input | 32 | B1 transmit word |
| tx_b2_word | input | 32 | B2 transmit word |
| tx_d_byte | input | 8 | Signalling byte to send |
| tx_b1_undr | output | 1 | B1 is sending idle fill this group |
| tx_b2_undr | output | 1 | B2 is sending idle fill this group |
| dout | output | 1 | Transmit line data |
| dout_en | output | 1 | Transmit slot active (output driver enable) |

## Verification
Two pairs of events can fall in the same clock.

The first pair is a completing receive word and a read strobe on the same channel. The bench provokes it by pulsing the B2 read strobe in exactly the clock after the falling `dcl` edge of the last B2 bit of frame 3. It expects full to stay set, the new word to appear and no overrun. In the same group, B1 is left unread so that the plain overrun path is exercised.

The second pair is a transmit load and a group-start sync. The bench provokes it by raising the B1 load strobe on the rising `dcl` edge that carries `fsync`. It then expects that word on the line at once, with B1 underrun low while B2, left unloaded, underruns.

A behavioural model in the bench predicts every output on every clock and judges both cases.

// File: rtl/isdn_pkg.sv
package isdn_pkg;

    typedef enum logic [1:0] {
        SL_IDLE = 2'd0,
        SL_B1   = 2'd1,
        SL_B2   = 2'd2,
        SL_D    = 2'd3
    } slot_e;

endpackage

// File: rtl/isdn_slot_fsm.sv
module isdn_slot_fsm
    import isdn_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int D_BITS = 2,
    parameter int FRAMES = 4,
    localparam int BIT_W = $clog2(BYTE_W),
    localparam int IDX_W = $clog2(FRAMES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dcl,
    input  logic             fsync,
    output slot_e            state,
    output logic [BIT_W-1:0] bit_idx,
    output logic [IDX_W-1:0] frame_idx,
    output logic             fall,
    output logic             group_start
);

    logic             dcl_q;
    slot_e            st_q, st_n;
    logic [BIT_W-1:0] bit_q, bit_n;
    logic [IDX_W-1:0] idx_q, idx_n;
    logic             rise, frame_end;

    assign rise = dcl & ~dcl_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dcl_q <= 1'b0;
            st_q  <= SL_IDLE;
            bit_q <= '0;
            idx_q <= '0;
        end else begin
            dcl_q <= dcl;
            st_q  <= st_n;
            bit_q <= bit_n;
            idx_q <= idx_n;
        end
    end

    // next state
    always_comb begin
        st_n      = st_q;
        bit_n     = bit_q;
        idx_n     = idx_q;
        frame_end = (st_q == SL_D) && (bit_q == BIT_W'(D_BITS - 1));
        if (rise) begin
            if (frame_end)
                idx_n = (idx_q == IDX_W'(FRAMES - 1)) ? '0 : idx_q + IDX_W'(1);
            if (fsync) begin
                st_n  = SL_B1;
                bit_n = '0;
            end else begin
                unique case (st_q)
                    SL_IDLE: st_n = SL_IDLE;
                    SL_B1: begin
                        if (bit_q == BIT_W'(BYTE_W - 1)) begin
                            st_n  = SL_B2;
                            bit_n = '0;
                        end else begin
                            bit_n = bit_q + BIT_W'(1);
                        end
                    end
                    SL_B2: begin
                        if (bit_q == BIT_W'(BYTE_W - 1)) begin
                            st_n  = SL_D;
                            bit_n = '0;
                        end else begin
                            bit_n = bit_q + BIT_W'(1);
                        end
                    end
                    SL_D: begin
                        if (frame_end) begin
                            st_n  = SL_IDLE;
                            bit_n = '0;
                        end else begin
                            bit_n = bit_q + BIT_W'(1);
                        end
                    end
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        state       = st_q;
        bit_idx     = bit_q;
        frame_idx   = idx_q;
        fall        = ~dcl & dcl_q;
        group_start = rise & fsync & (idx_n == '0);
    end

endmodule

// File: rtl/isdn_rx_lane.sv
module isdn_rx_lane #(
    parameter int BYTE_W = 8,
    parameter int FRAMES = 4,
    localparam int BIT_W  = $clog2(BYTE_W),
    localparam int IDX_W  = $clog2(FRAMES),
    localparam int WORD_W = BYTE_W * FRAMES,
    localparam int WPOS_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample,
    input  logic [BIT_W-1:0]  bit_idx,
    input  logic [IDX_W-1:0]  frame_idx,
    input  logic              din,
    input  logic              hdlc,
    input  logic              rd,
    output logic [WORD_W-1:0] word,
    output logic              full,
    output logic              ovr,
    output logic              done
);

    logic [BYTE_W-1:0] byte_q, byte_cur;
    logic [WORD_W-1:0] acc_q;
    logic [BIT_W-1:0]  pos;
    logic [WPOS_W-1:0] lane_off;
    logic              last;

    always_comb begin
        pos      = hdlc ? bit_idx : (BIT_W'(BYTE_W - 1) - bit_idx);
        lane_off = WPOS_W'((FRAMES - 1 - int'(frame_idx)) * BYTE_W);
        byte_cur = byte_q;
        byte_cur[pos] = din;
        last     = sample && (bit_idx == BIT_W'(BYTE_W - 1));
        done     = last && (frame_idx == IDX_W'(FRAMES - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_q <= '0;
            acc_q  <= '0;
            word   <= '0;
            full   <= 1'b0;
            ovr    <= 1'b0;
        end else begin
            if (sample) byte_q <= byte_cur;
            if (last)   acc_q[lane_off +: BYTE_W] <= byte_cur;
            if (done) begin
                word <= {acc_q[WORD_W-1:BYTE_W], byte_cur};
                full <= 1'b1;
                if (full && !rd) ovr <= 1'b1;
                else if (rd)     ovr <= 1'b0;
            end else if (rd) begin
                full <= 1'b0;
                ovr  <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/isdn_tx_lane.sv
module isdn_tx_lane #(
    parameter int BYTE_W = 8,
    parameter int FRAMES = 4,
    localparam int BIT_W  = $clog2(BYTE_W),
    localparam int IDX_W  = $clog2(FRAMES),
    localparam int WORD_W = BYTE_W * FRAMES,
    localparam int WPOS_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word_in,
    input  logic              group_start,
    input  logic              hdlc,
    input  logic [BIT_W-1:0]  bit_idx,
    input  logic [IDX_W-1:0]  frame_idx,
    output logic              bit_out,
    output logic              undr
);

    logic [WORD_W-1:0] hold_q, shadow_q;
    logic              pend_q;
    logic [BIT_W-1:0]  pos;
    logic [WPOS_W-1:0] lane_off;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q   <= '0;
            pend_q   <= 1'b0;
            shadow_q <= '1;
            undr     <= 1'b0;
        end else if (group_start) begin
            pend_q <= 1'b0;
            if (load) begin
                shadow_q <= word_in;
                undr     <= 1'b0;
            end else if (pend_q) begin
                shadow_q <= hold_q;
                undr     <= 1'b0;
            end else begin
                shadow_q <= '1;
                undr     <= 1'b1;
            end
        end else if (load) begin
            hold_q <= word_in;
            pend_q <= 1'b1;
        end
    end

    always_comb begin
        pos      = hdlc ? bit_idx : (BIT_W'(BYTE_W - 1) - bit_idx);
        lane_off = WPOS_W'((FRAMES - 1 - int'(frame_idx)) * BYTE_W);
        bit_out  = shadow_q[lane_off + WPOS_W'(pos)];
    end

endmodule

// File: rtl/isdn_frame_packer.sv
module isdn_frame_packer
    import isdn_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int D_BITS = 2,
    parameter int FRAMES = 4,
    localparam int BIT_W  = $clog2(BYTE_W),
    localparam int IDX_W  = $clog2(FRAMES),
    localparam int WORD_W = BYTE_W * FRAMES,
    localparam int DB_W   = D_BITS * FRAMES,
    localparam int DP_W   = $clog2(DB_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dcl,
    input  logic              fsync,
    input  logic              din,
    input  logic              mode_b1_hdlc,
    input  logic              mode_b2_hdlc,
    input  logic              rd_b1,
    input  logic              rd_b2,
    output logic [WORD_W-1:0] rx_b1_word,
    output logic [WORD_W-1:0] rx_b2_word,
    output logic              rx_b1_full,
    output logic              rx_b2_full,
    output logic              rx_b1_ovr,
    output logic              rx_b2_ovr,
    output logic [DB_W-1:0]   rx_d_byte,
    output logic              rx_d_stb,
    input  logic              tx_b1_load,
    input  logic              tx_b2_load,
    input  logic [WORD_W-1:0] tx_b1_word,
    input  logic [WORD_W-1:0] tx_b2_word,
    input  logic [DB_W-1:0]   tx_d_byte,
    output logic              tx_b1_undr,
    output logic              tx_b2_undr,
    output logic              dout,
    output logic              dout_en
);

    localparam int NCH = 2;

    slot_e            st;
    logic [BIT_W-1:0] bit_idx;
    logic [IDX_W-1:0] frame_idx;
    logic             fall, group_start;

    isdn_slot_fsm #(.BYTE_W(BYTE_W), .D_BITS(D_BITS), .FRAMES(FRAMES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .dcl(dcl), .fsync(fsync),
        .state(st), .bit_idx(bit_idx), .frame_idx(frame_idx),
        .fall(fall), .group_start(group_start)
    );

    logic [NCH-1:0]    hdlc_v, rd_v, ld_v, full_v, ovr_v, done_v, bit_v, undr_v;
    logic [WORD_W-1:0] rxw [NCH];
    logic [WORD_W-1:0] txw [NCH];

    assign hdlc_v = {mode_b2_hdlc, mode_b1_hdlc};
    assign rd_v   = {rd_b2, rd_b1};
    assign ld_v   = {tx_b2_load, tx_b1_load};
    assign txw[0] = tx_b1_word;
    assign txw[1] = tx_b2_word;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        localparam slot_e MY_SLOT = (ch == 0) ? SL_B1 : SL_B2;
        isdn_rx_lane #(.BYTE_W(BYTE_W), .FRAMES(FRAMES)) u_rx (
            .clk(clk), .rst_n(rst_n),
            .sample(fall && (st == MY_SLOT)),
            .bit_idx(bit_idx), .frame_idx(frame_idx), .din(din),
            .hdlc(hdlc_v[ch]), .rd(rd_v[ch]),
            .word(rxw[ch]), .full(full_v[ch]), .ovr(ovr_v[ch]), .done(done_v[ch])
        );
        isdn_tx_lane #(.BYTE_W(BYTE_W), .FRAMES(FRAMES)) u_tx (
            .clk(clk), .rst_n(rst_n), .load(ld_v[ch]), .word_in(txw[ch]),
            .group_start(group_start), .hdlc(hdlc_v[ch]),
            .bit_idx(bit_idx), .frame_idx(frame_idx),
            .bit_out(bit_v[ch]), .undr(undr_v[ch])
        );
    end

    assign rx_b1_word = rxw[0];
    assign rx_b2_word = rxw[1];
    assign rx_b1_full = full_v[0];
    assign rx_b2_full = full_v[1];
    assign rx_b1_ovr  = ovr_v[0];
    assign rx_b2_ovr  = ovr_v[1];
    assign tx_b1_undr = undr_v[0];
    assign tx_b2_undr = undr_v[1];

    // signalling channel, both directions
    logic [DB_W-1:0] d_acc_q, d_cur, d_shadow_q;
    logic [DP_W-1:0] d_pos;
    logic            d_samp, d_done;

    always_comb begin
        d_pos  = DP_W'(int'(frame_idx) * D_BITS + int'(bit_idx));
        d_samp = fall && (st == SL_D);
        d_done = d_samp && (bit_idx == BIT_W'(D_BITS - 1))
                        && (frame_idx == IDX_W'(FRAMES - 1));
        d_cur  = d_acc_q;
        d_cur[d_pos] = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d_acc_q    <= '0;
            rx_d_byte  <= '0;
            rx_d_stb   <= 1'b0;
            d_shadow_q <= '1;
        end else begin
            rx_d_stb <= d_done;
            if (d_samp)      d_acc_q    <= d_cur;
            if (d_done)      rx_d_byte  <= d_cur;
            if (group_start) d_shadow_q <= tx_d_byte;
        end
    end

    // line output from the current slot
    always_comb begin
        unique case (st)
            SL_IDLE: begin dout = 1'b1;              dout_en = 1'b0; end
            SL_B1:   begin dout = bit_v[0];          dout_en = 1'b1; end
            SL_B2:   begin dout = bit_v[1];          dout_en = 1'b1; end
            SL_D:    begin dout = d_shadow_q[d_pos]; dout_en = 1'b1; end
        endcase
    end

endmodule

// File: rtl/isdn_frame_packer_chk.sv
module isdn_frame_packer_chk
    import isdn_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_b1,
    input logic              rd_b2,
    input logic [1:0]        done_v,
    input logic              rx_b1_full,
    input logic              rx_b2_full,
    input logic              rx_b1_ovr,
    input logic              rx_b2_ovr,
    input logic [WORD_W-1:0] rx_b1_word,
    input logic              tx_b1_undr,
    input slot_e             st,
    input logic              dout,
    input logic              dout_en
);

    assert_idle_line_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> dout);

    assert_word_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !done_v[0] |=> $stable(rx_b1_word));

    assert_done_sets_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_v[0] |=> rx_b1_full);

    assert_rd_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_b1 && !done_v[0]) |=> (!rx_b1_full && !rx_b1_ovr));

    assert_overrun_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_v[0] && rx_b1_full && !rd_b1) |=> rx_b1_ovr);

    assert_collision_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_v[1] && rd_b2) |=> (rx_b2_full && !rx_b2_ovr));

    assert_underrun_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_b1_undr && st == SL_B1) |-> dout);

endmodule

bind isdn_frame_packer isdn_frame_packer_chk #(.WORD_W(WORD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_b1(rd_b1), .rd_b2(rd_b2), .done_v(done_v),
    .rx_b1_full(rx_b1_full), .rx_b2_full(rx_b2_full),
    .rx_b1_ovr(rx_b1_ovr), .rx_b2_ovr(rx_b2_ovr),
    .rx_b1_word(rx_b1_word), .tx_b1_undr(tx_b1_undr),
    .st(st), .dout(dout), .dout_en(dout_en)
);

// File: tb/sim_isdn_frame_packer.sv
module sim_isdn_frame_packer;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n = 1'b0, dcl = 1'b0, fsync = 1'b0, din = 1'b1;
    logic mode_b1_hdlc = 1'b1, mode_b2_hdlc = 1'b0;
    logic rd_b1 = 1'b0, rd_b2 = 1'b0, tx_b1_load = 1'b0, tx_b2_load = 1'b0;
    logic [31:0] tx_b1_word = '0, tx_b2_word = '0;
    logic [7:0]  tx_d_byte = 8'h5A;
    logic [31:0] rx_b1_word, rx_b2_word;
    logic        rx_b1_full, rx_b2_full, rx_b1_ovr, rx_b2_ovr, rx_d_stb;
    logic [7:0]  rx_d_byte;
    logic        tx_b1_undr, tx_b2_undr, dout, dout_en;

    isdn_frame_packer u0 (
        .clk(clk), .rst_n(rst_n), .dcl(dcl), .fsync(fsync), .din(din),
        .mode_b1_hdlc(mode_b1_hdlc), .mode_b2_hdlc(mode_b2_hdlc),
        .rd_b1(rd_b1), .rd_b2(rd_b2),
        .rx_b1_word(rx_b1_word), .rx_b2_word(rx_b2_word),
        .rx_b1_full(rx_b1_full), .rx_b2_full(rx_b2_full),
        .rx_b1_ovr(rx_b1_ovr), .rx_b2_ovr(rx_b2_ovr),
        .rx_d_byte(rx_d_byte), .rx_d_stb(rx_d_stb),
        .tx_b1_load(tx_b1_load), .tx_b2_load(tx_b2_load),
        .tx_b1_word(tx_b1_word), .tx_b2_word(tx_b2_word), .tx_d_byte(tx_d_byte),
        .tx_b1_undr(tx_b1_undr), .tx_b2_undr(tx_b2_undr),
        .dout(dout), .dout_en(dout_en)
    );

    int n_cmp = 0, n_bad = 0;

    // behavioural reference state
    int          m_slot, m_frame;
    bit          m_dclq;
    logic [31:0] m_acc [2], m_word [2], m_hold [2], m_shadow [2];
    logic [7:0]  m_byte [2];
    bit          m_full [2], m_ovr [2], m_pend [2], m_undr [2];
    logic [7:0]  m_dacc, m_dbyte, m_dshadow;
    bit          m_dstb;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic bit ch_mode(input int ch);
        return (ch == 0) ? mode_b1_hdlc : mode_b2_hdlc;
    endfunction

    task automatic model_reset();
        m_slot = -1; m_frame = 0; m_dclq = 0;
        for (int c = 0; c < 2; c++) begin
            m_acc[c] = '0; m_word[c] = '0; m_hold[c] = '0; m_shadow[c] = '1;
            m_byte[c] = '0; m_full[c] = 0; m_ovr[c] = 0; m_pend[c] = 0; m_undr[c] = 0;
        end
        m_dacc = '0; m_dbyte = '0; m_dshadow = '1; m_dstb = 0;
    endtask

    task automatic model_update();
        bit rise, fall, grp;
        bit cmp [2];
        bit rd [2], ld [2];
        logic [31:0] w [2];
        if (!rst_n) begin model_reset(); return; end
        rd[0] = rd_b1; rd[1] = rd_b2; ld[0] = tx_b1_load; ld[1] = tx_b2_load;
        w[0] = tx_b1_word; w[1] = tx_b2_word;
        rise = dcl && !m_dclq; fall = !dcl && m_dclq; m_dclq = dcl;
        cmp[0] = 0; cmp[1] = 0; m_dstb = 0;
        if (fall && m_slot >= 0) begin
            if (m_slot < 16) begin
                int c = m_slot / 8, k = m_slot % 8;
                int p = ch_mode(c) ? k : 7 - k;
                m_byte[c][p] = din;
                if (k == 7) begin
                    m_acc[c][(3 - m_frame) * 8 +: 8] = m_byte[c];
                    if (m_frame == 3) begin cmp[c] = 1; m_word[c] = m_acc[c]; end
                end
            end else begin
                int j = m_slot - 16;
                m_dacc[m_frame * 2 + j] = din;
                if (m_frame == 3 && j == 1) begin m_dbyte = m_dacc; m_dstb = 1; end
            end
        end
        for (int c = 0; c < 2; c++) begin
            if (cmp[c]) begin
                if (m_full[c] && !rd[c]) m_ovr[c] = 1;
                else if (rd[c])          m_ovr[c] = 0;
                m_full[c] = 1;
            end else if (rd[c]) begin
                m_full[c] = 0; m_ovr[c] = 0;
            end
        end
        grp = 0;
        if (rise) begin
            if (m_slot == 17) m_frame = (m_frame + 1) % 4;
            if (fsync)             m_slot = 0;
            else if (m_slot == 17) m_slot = -1;
            else if (m_slot >= 0)  m_slot = m_slot + 1;
            grp = fsync && (m_frame == 0);
        end
        for (int c = 0; c < 2; c++) begin
            if (grp) begin
                if (ld[c])        begin m_shadow[c] = w[c]; m_undr[c] = 0; end
                else if (m_pend[c]) begin m_shadow[c] = m_hold[c]; m_undr[c] = 0; end
                else              begin m_shadow[c] = '1; m_undr[c] = 1; end
                m_pend[c] = 0;
            end else if (ld[c]) begin
                m_hold[c] = w[c]; m_pend[c] = 1;
            end
        end
        if (grp) m_dshadow = tx_d_byte;
    endtask

    task automatic compare();
        if (m_slot < 0) begin
            chk("R1 idle line", {dout_en, dout}, 2'b01);
        end else if (m_slot < 16) begin
            int c = m_slot / 8, k = m_slot % 8;
            int p = ch_mode(c) ? k : 7 - k;
            logic b = m_shadow[c][(3 - m_frame) * 8 + p];
            chk(m_undr[c] ? "R8 underrun fill" : "R7 B-slot data", {dout_en, dout}, {1'b1, b});
        end else begin
            chk("R10 D slot data", {dout_en, dout}, {1'b1, m_dshadow[m_frame * 2 + m_slot - 16]});
        end
        chk("R4 b1 word", rx_b1_word, m_word[0]);
        chk("R4 b2 word", rx_b2_word, m_word[1]);
        chk("R5 full flags", {rx_b2_full, rx_b1_full}, {m_full[1], m_full[0]});
        chk("R6 overrun flags", {rx_b2_ovr, rx_b1_ovr}, {m_ovr[1], m_ovr[0]});
        chk("R9 D receive", {rx_d_stb, rx_d_byte}, {m_dstb, m_dbyte});
        chk("R8 underrun flags", {tx_b2_undr, tx_b1_undr}, {m_undr[1], m_undr[0]});
    endtask

    // staged inputs, applied at a falling clk edge
    logic s_rst = 0, s_dcl = 0, s_fs = 0, s_din = 1, s_rd1 = 0, s_rd2 = 0, s_ld1 = 0, s_ld2 = 0;

    task automatic step();
        @(negedge clk);
        compare();
        rst_n = s_rst; dcl = s_dcl; fsync = s_fs; din = s_din;
        rd_b1 = s_rd1; rd_b2 = s_rd2; tx_b1_load = s_ld1; tx_b2_load = s_ld2;
        model_update();
    endtask

    task automatic send_frame(input logic [7:0] b1, input logic [7:0] b2, input logic [1:0] d,
                              input int nslots, input int gap,
                              input logic [1:0] rd_mask, input logic [1:0] ld_mask);
        for (int s = 0; s < nslots; s++) begin
            logic bv;
            if (s < 8)       bv = b1[mode_b1_hdlc ? s : 7 - s];
            else if (s < 16) bv = b2[mode_b2_hdlc ? s - 8 : 15 - s];
            else             bv = d[s - 16];
            for (int i = 0; i < 8; i++) begin
                s_dcl = (i < 4); s_fs = (s == 0 && i < 4); s_din = bv;
                s_rd1 = rd_mask[0] && s == 7  && i == 4;
                s_rd2 = rd_mask[1] && s == 15 && i == 4;
                s_ld1 = ld_mask[0] && s == 0 && i == 0;
                s_ld2 = ld_mask[1] && s == 0 && i == 0;
                step();
            end
        end
        s_rd1 = 0; s_rd2 = 0; s_ld1 = 0; s_ld2 = 0; s_fs = 0; s_din = 1;
        for (int g = 0; g < gap; g++)
            for (int i = 0; i < 8; i++) begin s_dcl = (i < 4); step(); end
        s_dcl = 0;
    endtask

    task automatic pulse(input logic [1:0] rdm, input logic [1:0] ldm);
        s_rd1 = rdm[0]; s_rd2 = rdm[1]; s_ld1 = ldm[0]; s_ld2 = ldm[1];
        step();
        s_rd1 = 0; s_rd2 = 0; s_ld1 = 0; s_ld2 = 0;
        step(); step();
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog R1 act=hung exp=finished");
        summary();
        $finish;
    end

    initial begin
        model_reset();
        for (int i = 0; i < 4; i++) step();
        // reset state: R1 line idle, R5 flags clear
        chk("R1 reset line", {dout_en, dout}, 2'b01);
        chk("R5 reset flags", {rx_b1_full, rx_b2_full, rx_b1_ovr, rx_b2_ovr}, 4'b0);
        s_rst = 1;
        for (int i = 0; i < 4; i++) step();

        // group 1: B1 LSB first (R2), B2 MSB first (R3), nothing loaded (R8)
        send_frame(8'h11, 8'hA1, 2'd1, 18, 2, 2'b00, 2'b00);
        send_frame(8'h22, 8'hB2, 2'd2, 18, 2, 2'b00, 2'b00);
        send_frame(8'h33, 8'hC3, 2'd3, 18, 2, 2'b00, 2'b00);
        send_frame(8'h44, 8'hD4, 2'd0, 18, 2, 2'b00, 2'b00);
        chk("R2 R4 b1 hdlc word", rx_b1_word, 32'h11223344);
        chk("R3 R4 b2 plain word", rx_b2_word, 32'hA1B2C3D4);
        chk("R5 full after group", {rx_b2_full, rx_b1_full}, 2'b11);
        chk("R9 D byte packing", rx_d_byte, 8'h39);
        chk("R8 underrun held", {tx_b2_undr, tx_b1_undr}, 2'b11);

        pulse(2'b11, 2'b00);
        chk("R5 read clears full", {rx_b2_full, rx_b1_full}, 2'b00);
        tx_b1_word = 32'hDEADBEEF; tx_b2_word = 32'h0F1E2D3C; tx_d_byte = 8'hC6;
        pulse(2'b00, 2'b11);

        // group 2: an aborted frame inside the group (R11), loaded words sent (R7, R10)
        send_frame(8'h01, 8'h10, 2'd3, 18, 2, 2'b00, 2'b00);
        chk("R7 no underrun with word", {tx_b2_undr, tx_b1_undr}, 2'b00);
        send_frame(8'hFF, 8'hFF, 2'd0, 5, 1, 2'b00, 2'b00);
        send_frame(8'h02, 8'h20, 2'd3, 18, 2, 2'b00, 2'b00);
        send_frame(8'h03, 8'h30, 2'd0, 18, 2, 2'b00, 2'b00);
        send_frame(8'h04, 8'h40, 2'd1, 18, 2, 2'b00, 2'b00);
        chk("R11 abort keeps b1 index", rx_b1_word, 32'h01020304);
        chk("R11 abort keeps b2 index", rx_b2_word, 32'h10203040);
        chk("R9 D byte second group", rx_d_byte, 8'h4F);

        // group 3: back-to-back frames (R11), load at group start (R12),
        // B1 overrun and B2 read/complete collision (R6), modes swapped
        mode_b1_hdlc = 0; mode_b2_hdlc = 1;
        tx_b1_word = 32'h13579BDF;
        send_frame(8'hA0, 8'h0A, 2'd2, 18, 0, 2'b00, 2'b01);
        chk("R12 load at group start", {tx_b2_undr, tx_b1_undr}, 2'b10);
        send_frame(8'hB0, 8'h0B, 2'd1, 18, 0, 2'b00, 2'b00);
        send_frame(8'hC0, 8'h0C, 2'd0, 18, 0, 2'b00, 2'b00);
        send_frame(8'hD0, 8'h0D, 2'd3, 18, 2, 2'b10, 2'b00);
        chk("R11 R3 back-to-back b1 word", rx_b1_word, 32'hA0B0C0D0);
        chk("R2 b2 hdlc word", rx_b2_word, 32'h0A0B0C0D);
        chk("R6 b1 overrun", rx_b1_ovr, 1'b1);
        chk("R6 b2 collision", {rx_b2_full, rx_b2_ovr}, 2'b10);

        pulse(2'b11, 2'b00);
        chk("R6 read clears overrun", {rx_b1_ovr, rx_b1_full}, 2'b00);
        for (int i = 0; i < 8; i++) step();

        summary();
        $finish;
    end

endmodule